// File: doc/BRIEF.md
# Burst-Mode DMA Controller

This block is a single-channel direct memory access engine. Software sets it up with a first word address, a number of words, a transfer direction and a channel mask. A peripheral then raises a service request. If the channel is armed and unmasked, the controller asks the CPU for the system bus through a hold request. Once the hold acknowledge has been captured by a register, the controller owns the bus. It runs one read cycle and one write cycle for each word, back to back, until the whole block has moved.

On the final word the controller lets go of the bus at once and gives the peripheral a one-cycle end strobe. It also raises a sticky interrupt so that software can inspect the result. The CPU makes no bus accesses between the grant and the release. The controller drives the address, the write data and all four read/write strobes itself.

Top module: `dma_burst_ctrl`

## Requirements
- R1: While and after reset, every output is low and the bus address and write data are zero.
- R2: A start pulse with a nonzero word count, given while idle or armed, loads the address, count, mask and direction and arms the channel. A start pulse with a count of zero is ignored.
- R3: An armed channel with its mask bit at 1 ignores the peripheral request and keeps the hold request low. With the mask at 0, a request raises the hold request in the next cycle.
- R4: The hold acknowledge passes through one register. The first bus cycle appears in the second cycle after the acknowledge is first sampled high, and no strobe or bus address is driven before it.
- R5: Each word takes one read cycle and then one write cycle. With direction 0 the read is a memory read and the write is an I/O write. With direction 1 the read is an I/O read and the write is a memory write. The write data equals the data read in the cycle before.
- R6: The first word uses the programmed address. The address rises by one, wrapping at the top of its range, after each write. Exactly the programmed number of words is moved.
- R7: The hold request stays high from the request through the last write cycle and drops in the next cycle. That cycle carries a single-cycle end strobe to the peripheral.
- R8: The acknowledge to the peripheral is high during the read and write cycles and low at all other times.
- R9: The interrupt rises in the same cycle as the end strobe. It stays high until an interrupt-clear input is sampled. If a set and a clear arrive in the same cycle, the set wins.
- R10: A start pulse that arrives while a request, a transfer or the end cycle is in progress has no effect on the running block.
- R11: At most one of the four strobes is high in any cycle. The bus address and write data read zero when the bus is not owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_go | input | 1 | Start pulse; loads the cfg_* values |
| cfg_addr | input | AW | First word address |
| cfg_count | input | CW | Number of words to move |
| cfg_mask | input | 1 | 1 blocks peripheral requests |
| cfg_dir | input | 1 | 0 memory to I/O, 1 I/O to memory |
| irq_clr | input | 1 | Clears the interrupt |
| dev_req | input | 1 | Peripheral service request |
| dev_ack | output | 1 | Data phase in progress |
| dev_end | output | 1 | One-cycle end-of-block strobe |
| hold_req | output | 1 | Bus request to the CPU |
| hold_ack | input | 1 | Bus grant from the CPU |
| bus_addr | output | AW | Word address |
| bus_rdata | input | DW | Read data from memory or I/O |
| bus_wdata | output | DW | Write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| irq | output | 1 | Sticky completion interrupt |

## Verification
Every output is a decode of registered state, so a wrong state register shows at the ports in the very next cycle. Typical symptoms are a strobe on the wrong side, a hold request that drops too early or lingers, or an address that skips or repeats. A word count that is off by one appears only at the end of the block, as one write too many or too few before the end strobe. A lost mask or an ignored zero count shows as a hold request where none should be. The bench compares every output against its own model in every cycle, so each of these faults is reported in the cycle it first appears.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_HOLD,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } dmab_state_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } dmab_strobe_t;

    localparam logic DIR_MEM_TO_IO = 1'b0;

    function automatic dmab_strobe_t strobe_decode(dmab_state_t st, logic dir);
        dmab_strobe_t s;
        s = '0;
        if (st == ST_READ) begin
            if (dir == DIR_MEM_TO_IO) s.mem_rd = 1'b1;
            else                      s.io_rd  = 1'b1;
        end else if (st == ST_WRITE) begin
            if (dir == DIR_MEM_TO_IO) s.io_wr  = 1'b1;
            else                      s.mem_wr = 1'b1;
        end
        return s;
    endfunction

    function automatic logic owns_bus(dmab_state_t st);
        return (st == ST_READ) || (st == ST_WRITE);
    endfunction

endpackage

// File: rtl/dmab_req_gate.sv
module dmab_req_gate (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic mask,
    input  logic dev_req,
    input  logic hold_ack,
    output logic req_ok,
    output logic grant_seen
);
    // only an unmasked request on an armed channel reaches the bus request
    assign req_ok = armed && dev_req && !mask;

    // grant from the CPU is captured before it is acted upon
    always_ff @(posedge clk) begin
        if (rst) grant_seen <= 1'b0;
        else     grant_seen <= hold_ack;
    end
endmodule

// File: rtl/dmab_datapath.sv
module dmab_datapath #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          capture,
    input  logic          step,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_count,
    input  logic          ld_mask,
    input  logic          ld_dir,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          mask,
    output logic          dir,
    output logic          last
);
    localparam logic [CW-1:0] ONE_WORD = CW'(1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            remain <= '0;
            data   <= '0;
            mask   <= 1'b1;
            dir    <= 1'b0;
        end else begin
            if (load) begin
                addr   <= ld_addr;
                remain <= ld_count;
                mask   <= ld_mask;
                dir    <= ld_dir;
            end else if (step) begin
                addr   <= addr + AW'(1);
                remain <= remain - ONE_WORD;
            end
            if (capture) data <= rdata;
        end
    end

    assign last = (remain == ONE_WORD);
endmodule

// File: rtl/dmab_fsm.sv
module dmab_fsm
    import dma_burst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go_ok,
    input  logic        req_ok,
    input  logic        grant_seen,
    input  logic        last,
    output dmab_state_t state,
    output logic        load
);
    dmab_state_t nxt;

    assign load = go_ok && (state == ST_IDLE || state == ST_ARMED);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go_ok) nxt = ST_ARMED;
            ST_ARMED:  if (!go_ok && req_ok) nxt = ST_HOLD;
            ST_HOLD:   if (grant_seen) nxt = ST_READ;
            ST_READ:   nxt = ST_WRITE;
            ST_WRITE:  nxt = last ? ST_FINISH : ST_READ;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
    import dma_burst_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_go,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_mask,
    input  logic          cfg_dir,
    input  logic          irq_clr,
    input  logic          dev_req,
    output logic          dev_ack,
    output logic          dev_end,
    output logic          hold_req,
    input  logic          hold_ack,
    output logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_rdata,
    output logic [DW-1:0] bus_wdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          io_rd,
    output logic          io_wr,
    output logic          irq
);
    dmab_state_t  state;
    dmab_strobe_t stb;
    logic         load, req_ok, grant_seen, last, go_ok;
    logic         mask_q, dir_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          irq_q;

    assign go_ok = cfg_go && (cfg_count != '0);

    dmab_fsm u_fsm (
        .clk(clk), .rst(rst), .go_ok(go_ok), .req_ok(req_ok),
        .grant_seen(grant_seen), .last(last), .state(state), .load(load)
    );

    dmab_req_gate u_gate (
        .clk(clk), .rst(rst), .armed(state == ST_ARMED), .mask(mask_q),
        .dev_req(dev_req), .hold_ack(hold_ack), .req_ok(req_ok),
        .grant_seen(grant_seen)
    );

    dmab_datapath #(.AW(AW), .DW(DW), .CW(CW)) u_dp (
        .clk(clk), .rst(rst), .load(load),
        .capture(state == ST_READ), .step(state == ST_WRITE),
        .ld_addr(cfg_addr), .ld_count(cfg_count), .ld_mask(cfg_mask),
        .ld_dir(cfg_dir), .rdata(bus_rdata), .addr(addr_q), .data(data_q),
        .mask(mask_q), .dir(dir_q), .last(last)
    );

    // completion interrupt: setting has precedence over clearing
    always_ff @(posedge clk) begin
        if (rst)                            irq_q <= 1'b0;
        else if (state == ST_WRITE && last) irq_q <= 1'b1;
        else if (irq_clr)                   irq_q <= 1'b0;
    end

    assign stb       = strobe_decode(state, dir_q);
    assign mem_rd    = stb.mem_rd;
    assign mem_wr    = stb.mem_wr;
    assign io_rd     = stb.io_rd;
    assign io_wr     = stb.io_wr;
    assign dev_ack   = owns_bus(state);
    assign hold_req  = owns_bus(state) || (state == ST_HOLD);
    assign dev_end   = (state == ST_FINISH);
    assign bus_addr  = owns_bus(state) ? addr_q : '0;
    assign bus_wdata = (state == ST_WRITE) ? data_q : '0;
    assign irq       = irq_q;
endmodule

// File: rtl/dmab_checker.sv
module dmab_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          hold_req,
    input logic          hold_ack,
    input logic          dev_ack,
    input logic          dev_end,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          io_rd,
    input logic          io_wr,
    input logic [AW-1:0] bus_addr,
    input logic          irq,
    input logic          irq_clr
);
    logic any_rd, any_wr;
    assign any_rd = mem_rd || io_rd;
    assign any_wr = mem_wr || io_wr;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr})); // R11
    AST_DRIVE_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        (any_rd || any_wr) |-> $past(hold_ack)); // R4
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        any_rd |=> any_wr); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (any_rd && $past(any_wr)) |-> (bus_addr == $past(bus_addr) + AW'(1))); // R6
    AST_END_RELEASES: assert property (@(posedge clk) disable iff (rst)
        dev_end |-> (!hold_req && $past(any_wr))); // R7
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dev_end |=> !dev_end); // R7
    AST_ACK_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        dev_ack |-> (any_rd || any_wr)); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R9
    AST_IRQ_WITH_END: assert property (@(posedge clk) disable iff (rst)
        dev_end |-> irq); // R9
endmodule

bind dma_burst_ctrl dmab_checker #(.AW(AW)) u_dmab_chk (
    .clk(clk), .rst(rst), .hold_req(hold_req), .hold_ack(hold_ack),
    .dev_ack(dev_ack), .dev_end(dev_end), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .bus_addr(bus_addr), .irq(irq),
    .irq_clr(irq_clr)
);

// File: tb/test_dma_burst_ctrl.sv
module test_dma_burst_ctrl;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_go = 1'b0, cfg_mask = 1'b0, cfg_dir = 1'b0, irq_clr = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic dev_req = 1'b0, hold_ack = 1'b0;
    logic dev_ack, dev_end, hold_req, mem_rd, mem_wr, io_rd, io_wr, irq;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_rdata, bus_wdata;

    int n_cmp = 0, n_bad = 0, cyc = 0, ack_delay = 0, ack_cnt = 0;

    always #2 clk = ~clk; // 250 MHz

    function automatic logic [DW-1:0] src_word(logic [AW-1:0] a, logic from_io);
        return {a ^ (from_io ? 16'h3C3C : 16'h0000), ~a};
    endfunction

    assign bus_rdata = (mem_rd || io_rd) ? src_word(bus_addr, io_rd) : '0;

    dma_burst_ctrl #(.AW(AW), .DW(DW), .CW(CW)) i_dma_burst_ctrl (
        .clk(clk), .rst(rst), .cfg_go(cfg_go), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_mask(cfg_mask), .cfg_dir(cfg_dir),
        .irq_clr(irq_clr), .dev_req(dev_req), .dev_ack(dev_ack),
        .dev_end(dev_end), .hold_req(hold_req), .hold_ack(hold_ack),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .irq(irq)
    );

    // reference model: 0 idle, 1 armed, 2 waiting grant, 3 read, 4 write, 5 end
    int m_st = 0, m_cnt = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;
    logic m_mask = 1'b1, m_dir = 1'b0, m_ackq = 1'b0, m_irq = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_addr = '0; m_data = '0;
            m_mask = 1'b1; m_dir = 1'b0; m_ackq = 1'b0; m_irq = 1'b0;
        end else begin
            if (m_st == 4 && m_cnt == 1) m_irq = 1'b1;
            else if (irq_clr)            m_irq = 1'b0;
            if ((m_st == 0 || m_st == 1) && cfg_go && cfg_count != 0) begin
                m_st = 1; m_addr = cfg_addr; m_cnt = int'(cfg_count);
                m_mask = cfg_mask; m_dir = cfg_dir;
            end else begin
                case (m_st)
                    1: if (dev_req && !m_mask) m_st = 2;
                    2: if (m_ackq) m_st = 3;
                    3: begin m_data = src_word(m_addr, m_dir); m_st = 4; end
                    4: begin
                        m_st = (m_cnt == 1) ? 5 : 3;
                        m_addr = m_addr + 1'b1; m_cnt = m_cnt - 1;
                    end
                    5: m_st = 0;
                    default: ;
                endcase
            end
            m_ackq = hold_ack;
        end
    end

    task automatic check(string tag, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // compare every output against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        check("R7", "hold_req", hold_req, m_st >= 2 && m_st <= 4);
        check("R8", "dev_ack", dev_ack, m_st == 3 || m_st == 4);
        check("R7", "dev_end", dev_end, m_st == 5);
        check("R5", "mem_rd", mem_rd, m_st == 3 && !m_dir);
        check("R5", "io_rd", io_rd, m_st == 3 && m_dir);
        check("R5", "io_wr", io_wr, m_st == 4 && !m_dir);
        check("R5", "mem_wr", mem_wr, m_st == 4 && m_dir);
        check("R6", "bus_addr", bus_addr, (m_st == 3 || m_st == 4) ? m_addr : 0);
        check("R11", "bus_wdata", bus_wdata, m_st == 4 ? m_data : 0);
        check("R9", "irq", irq, m_irq);
        // CPU side: grants after ack_delay cycles, holds while requested
        if (hold_req) begin
            if (ack_cnt >= ack_delay) hold_ack <= 1'b1;
            else ack_cnt++;
        end else begin
            hold_ack <= 1'b0; ack_cnt = 0;
        end
    end

    task automatic start(logic [AW-1:0] a, int n, logic msk, logic d);
        @(negedge clk);
        cfg_go = 1'b1; cfg_addr = a; cfg_count = CW'(n); cfg_mask = msk; cfg_dir = d;
        @(negedge clk);
        cfg_go = 1'b0;
    endtask

    task automatic wait_end();
        int t = 0;
        while (dev_end !== 1'b1 && t < 400) begin @(negedge clk); t++; end
        check("R7", "end strobe seen", dev_end, 1);
        @(negedge clk);
    endtask

    initial begin
        int words;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset outputs",
              {hold_req, dev_ack, dev_end, mem_rd, mem_wr, io_rd, io_wr, irq}, 0);
        rst = 1'b0;

        // R2 R4 R5 R6: memory to I/O, three words, grant after two cycles
        ack_delay = 2;
        start(16'h0010, 3, 1'b0, 1'b0);
        dev_req = 1'b1; @(negedge clk); dev_req = 1'b0;
        words = 0;
        for (int i = 0; i < 60 && dev_end !== 1'b1; i++) begin
            if (io_wr) words++;
            @(negedge clk);
        end
        check("R6", "words moved", words, 3);
        wait_end();

        // R9: interrupt sticky, then cleared
        repeat (3) @(negedge clk);
        check("R9", "irq held", irq, 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        check("R9", "irq cleared", irq, 0);

        // R5: I/O to memory, one word, immediate grant
        ack_delay = 0;
        start(16'h0200, 1, 1'b0, 1'b1);
        dev_req = 1'b1; @(negedge clk); dev_req = 1'b0;
        wait_end();

        // R2: zero count ignored, request produces no hold
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        start(16'h0300, 0, 1'b0, 1'b0);
        dev_req = 1'b1; repeat (6) @(negedge clk); dev_req = 1'b0;
        check("R2", "zero count no hold", hold_req, 0);

        // R3: masked channel ignores requests, then unmasked by a fresh start
        start(16'h0400, 2, 1'b1, 1'b0);
        dev_req = 1'b1; repeat (6) @(negedge clk);
        check("R3", "masked no hold", hold_req, 0);
        start(16'h0400, 2, 1'b0, 1'b0);
        @(negedge clk);
        check("R3", "unmasked hold", hold_req, 1);
        dev_req = 1'b0;
        // R9: clear held through the end, set wins
        irq_clr = 1'b1;
        wait_end();
        irq_clr = 1'b0;

        // R10: start during a transfer is ignored; address wraps (R6)
        ack_delay = 3;
        start(16'hFFFE, 4, 1'b0, 1'b1);
        dev_req = 1'b1; @(negedge clk); dev_req = 1'b0;
        repeat (6) @(negedge clk);
        start(16'h0800, 9, 1'b0, 1'b0);
        check("R10", "still mem_wr side", mem_rd || io_wr, 0);
        wait_end();
        repeat (4) @(negedge clk);
        check("R10", "idle after block", hold_req, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule